// File: doc/BRIEF.md
# Data Access Region and Protection Guard

This block sits between a load/store unit and the memory system and decides, for every 32-bit virtual data access, how it is handled. From the address, the privilege level, the access direction, the translation-enable bit and the store-queue lock bit, it sorts the access into one of four cases. The access may pass through unchanged, pass through with its top three bits cleared, be rejected with an address error, or be translated through a TLB entry.

The TLB lookup itself is done outside. The block receives the lookup result: a hit flag, a multi-hit flag, the matched entry's flag bits and its physical page number. For translated accesses it checks the entry's permission and dirty bits and merges the physical page with the page offset, using the entry's page size. Every TLB-class fault also produces the values to load into the fault-address register and the page-table-entry-high register. All results are registered, so they appear one clock after the request.

Top module: `acc_region_guard`

## Requirements
- R1: A privileged access with address bits 31:29 all set is output unchanged, with no fault.
- R2: A privileged access in 0x80000000..0xBFFFFFFF is output ANDed with 0x1FFFFFFF, with no fault.
- R3: A user access with bit 31 set raises an address error: fault bit 0 for a read, bit 1 for a write. The exception is 0xE0000000..0xE3FFFFFF while `sq_lock_i` is 0, which is output unchanged.
- R4: With `xlat_en_i` at 0, every address not covered by R1 to R3 is output ANDed with 0x1FFFFFFF, with no fault. This covers addresses below 0x80000000 and privileged 0xC0000000..0xDFFFFFFF.
- R5: A translated access with `tlb_multi_i` set raises fault bit 2 (the reset-class multi-hit), whatever `tlb_hit_i` is. If both are clear, it raises a miss: bit 3 for a read, bit 4 for a write.
- R6: A translated user read of an entry whose user bit (flag bit 6) is clear raises fault bit 5 (read protection).
- R7: A translated privileged write needs the writable bit (flag bit 5). A user write needs flag bits 5 and 6 both set. Failing either rule raises fault bit 6 (write protection).
- R8: A translated write that passes R7 but has the dirty bit (flag bit 2) clear raises fault bit 7 (initial page write).
- R9: A translated access without a fault outputs (PPN AND mask) OR (vaddr AND NOT mask). The mask clears the low 10, 12, 16 or 20 bits when {flag bit 7, flag bit 4} is 00, 01, 10 or 11.
- R10: On any of fault bits 2..7, `tlb_fault_o` is 1, `tea_o` equals the virtual address, and `pteh_o` is {vaddr[31:10], pteh_i[9:0]}. Otherwise all three are 0, including on address errors.
- R11: At most one fault bit is set, in priority address error, multi-hit, miss, protection, initial write. `paddr_o` is 0 whenever a fault is set.
- R12: Results appear one clock after a `valid_i` cycle with `done_o` at 1. In a cycle after `valid_i` was 0, `done_o`, `fault_o`, `paddr_o` and `tlb_fault_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access request this cycle |
| vaddr_i | input | 32 | Virtual address |
| write_i | input | 1 | 1 for write, 0 for read |
| priv_i | input | 1 | 1 for privileged mode |
| xlat_en_i | input | 1 | Address translation enable |
| sq_lock_i | input | 1 | 1 blocks user access to the store-queue window |
| tlb_hit_i | input | 1 | External TLB found a single match |
| tlb_multi_i | input | 1 | External TLB found several matches |
| tlb_flags_i | input | 9 | Matched entry flag bits |
| tlb_ppn_i | input | 32 | Matched entry physical page (address form) |
| pteh_i | input | 32 | Current page-table-entry-high value |
| done_o | output | 1 | Result valid |
| paddr_o | output | 32 | Physical address |
| fault_o | output | 8 | One-hot fault vector |
| tlb_fault_o | output | 1 | Load `tea_o` and `pteh_o` |
| tea_o | output | 32 | Fault-address register value |
| pteh_o | output | 32 | New page-table-entry-high value |

## Verification
The bench aims at the region edges: 0xBFFFFFFF against 0xC0000000, 0xDFFFFFFF against 0xE0000000, and 0xE3FFFFFF against 0xE4000000 with the lock both set and clear. An off-by-one decode there would strip an address that should pass, or let a user access through that must error. It mixes multi-hit with hit, and protection failures with clear dirty bits. A wrong priority order would show up as two fault bits set, or as the wrong one. It sweeps all four page sizes with random offsets, so a mask that is off by one size leaks page-number bits into the offset. It also checks that address errors leave `tea_o` and `pteh_o` untouched.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned FLAG_W  = 9;
  localparam int unsigned FAULT_W = 8;
  localparam int unsigned VPN_LSB = 10;

  // flag bit positions of a TLB entry
  localparam int unsigned FL_SZ_LO = 4;
  localparam int unsigned FL_SZ_HI = 7;
  localparam int unsigned FL_USER  = 6;
  localparam int unsigned FL_WR    = 5;
  localparam int unsigned FL_DIRTY = 2;

  // fault vector bit positions
  localparam int unsigned F_AERR_RD = 0;
  localparam int unsigned F_AERR_WR = 1;
  localparam int unsigned F_MULTI   = 2;
  localparam int unsigned F_MISS_RD = 3;
  localparam int unsigned F_MISS_WR = 4;
  localparam int unsigned F_PROT_RD = 5;
  localparam int unsigned F_PROT_WR = 6;
  localparam int unsigned F_INIT_WR = 7;

  typedef enum logic [1:0] {
    RG_STRIP = 2'd0,
    RG_PASS  = 2'd1,
    RG_AERR  = 2'd2,
    RG_XLAT  = 2'd3
  } region_e;

  // page offset width for {size_hi, size_lo}
  function automatic int unsigned page_bits(input logic [1:0] sz);
    case (sz)
      2'b00:   page_bits = 10;
      2'b01:   page_bits = 12;
      2'b10:   page_bits = 16;
      default: page_bits = 20;
    endcase
  endfunction
endpackage

// File: rtl/acc_region_dec.sv
module acc_region_dec
  import acc_guard_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic          priv_i,
  input  logic          xlat_en_i,
  input  logic          sq_lock_i,
  output region_e       region_o
);
  logic [2:0] top3;
  logic       sq_win;

  assign top3   = vaddr_i[AW-1 -: 3];
  // store-queue window: top six bits 111000
  assign sq_win = (vaddr_i[AW-1 -: 6] == 6'b111000);

  always_comb begin
    region_o = RG_STRIP;
    if (vaddr_i[AW-1] && !priv_i) begin
      region_o = (sq_win && !sq_lock_i) ? RG_PASS : RG_AERR;
    end else if (vaddr_i[AW-1] && top3 == 3'b111) begin
      region_o = RG_PASS;
    end else if (vaddr_i[AW-1] && !vaddr_i[AW-2]) begin
      region_o = RG_STRIP;
    end else begin
      region_o = xlat_en_i ? RG_XLAT : RG_STRIP;
    end
  end
endmodule

// File: rtl/acc_perm_chk.sv
module acc_perm_chk
  import acc_guard_pkg::*;
(
  input  logic              xlat_i,
  input  logic              write_i,
  input  logic              priv_i,
  input  logic              hit_i,
  input  logic              multi_i,
  input  logic              user_ok_i,
  input  logic              wr_ok_i,
  input  logic              dirty_i,
  output logic [FAULT_W-1:0] fault_o
);
  logic wr_allowed;

  assign wr_allowed = priv_i ? wr_ok_i : (wr_ok_i && user_ok_i);

  // priority: multi-hit, miss, protection, initial write
  always_comb begin
    fault_o = '0;
    if (xlat_i) begin
      if (multi_i) begin
        fault_o[F_MULTI] = 1'b1;
      end else if (!hit_i) begin
        fault_o[write_i ? F_MISS_WR : F_MISS_RD] = 1'b1;
      end else if (!write_i) begin
        if (!priv_i && !user_ok_i) fault_o[F_PROT_RD] = 1'b1;
      end else if (!wr_allowed) begin
        fault_o[F_PROT_WR] = 1'b1;
      end else if (!dirty_i) begin
        fault_o[F_INIT_WR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_addr_merge.sv
module acc_addr_merge
  import acc_guard_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] vaddr_i,
  input  logic [AW-1:0] ppn_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] paddr_o
);
  int unsigned off_bits;
  assign off_bits = page_bits(size_i);

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign paddr_o[i] = (i >= off_bits) ? ppn_i[i] : vaddr_i[i];
  end
endmodule

// File: rtl/acc_region_guard.sv
module acc_region_guard
  import acc_guard_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FLAG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [AW-1:0] vaddr_i,
  input  logic          write_i,
  input  logic          priv_i,
  input  logic          xlat_en_i,
  input  logic          sq_lock_i,
  input  logic          tlb_hit_i,
  input  logic          tlb_multi_i,
  input  logic [FW-1:0] tlb_flags_i,
  input  logic [AW-1:0] tlb_ppn_i,
  input  logic [AW-1:0] pteh_i,
  output logic          done_o,
  output logic [AW-1:0] paddr_o,
  output logic [FAULT_W-1:0] fault_o,
  output logic          tlb_fault_o,
  output logic [AW-1:0] tea_o,
  output logic [AW-1:0] pteh_o
);
  localparam logic [AW-1:0] STRIP_MASK = {3'b000, {(AW-3){1'b1}}};

  region_e            region;
  logic [FAULT_W-1:0] tlb_flt;
  logic [FAULT_W-1:0] fault_d;
  logic [AW-1:0]      xlat_pa;
  logic [AW-1:0]      paddr_d;
  logic               tlbf_d;
  logic               unused_flags;

  assign unused_flags = ^{tlb_flags_i[FW-1:FL_SZ_HI+1], tlb_flags_i[3], tlb_flags_i[1:0]};

  acc_region_dec #(.AW(AW)) u_dec (
    .vaddr_i   (vaddr_i),
    .priv_i    (priv_i),
    .xlat_en_i (xlat_en_i),
    .sq_lock_i (sq_lock_i),
    .region_o  (region)
  );

  acc_perm_chk u_perm (
    .xlat_i    (region == RG_XLAT),
    .write_i   (write_i),
    .priv_i    (priv_i),
    .hit_i     (tlb_hit_i),
    .multi_i   (tlb_multi_i),
    .user_ok_i (tlb_flags_i[FL_USER]),
    .wr_ok_i   (tlb_flags_i[FL_WR]),
    .dirty_i   (tlb_flags_i[FL_DIRTY]),
    .fault_o   (tlb_flt)
  );

  acc_addr_merge #(.AW(AW)) u_merge (
    .vaddr_i (vaddr_i),
    .ppn_i   (tlb_ppn_i),
    .size_i  ({tlb_flags_i[FL_SZ_HI], tlb_flags_i[FL_SZ_LO]}),
    .paddr_o (xlat_pa)
  );

  always_comb begin
    fault_d = tlb_flt;
    paddr_d = '0;
    case (region)
      RG_PASS:  paddr_d = vaddr_i;
      RG_STRIP: paddr_d = vaddr_i & STRIP_MASK;
      RG_AERR: begin
        fault_d = '0;
        fault_d[write_i ? F_AERR_WR : F_AERR_RD] = 1'b1;
      end
      default:  paddr_d = (tlb_flt == '0) ? xlat_pa : '0;
    endcase
  end

  assign tlbf_d = (region == RG_XLAT) && (tlb_flt != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      paddr_o     <= '0;
      fault_o     <= '0;
      tlb_fault_o <= 1'b0;
      tea_o       <= '0;
      pteh_o      <= '0;
    end else begin
      done_o      <= valid_i;
      paddr_o     <= valid_i ? paddr_d : '0;
      fault_o     <= valid_i ? fault_d : '0;
      tlb_fault_o <= valid_i && tlbf_d;
      tea_o       <= (valid_i && tlbf_d) ? vaddr_i : '0;
      pteh_o      <= (valid_i && tlbf_d) ?
                     {vaddr_i[AW-1:VPN_LSB], pteh_i[VPN_LSB-1:0]} : '0;
    end
  end
endmodule

// File: rtl/acc_region_guard_chk.sv
module acc_region_guard_chk
  import acc_guard_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned FW = FLAG_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [AW-1:0] vaddr_i,
  input logic          write_i,
  input logic          priv_i,
  input logic          xlat_en_i,
  input logic          sq_lock_i,
  input logic          tlb_hit_i,
  input logic          tlb_multi_i,
  input logic [FW-1:0] tlb_flags_i,
  input logic [AW-1:0] tlb_ppn_i,
  input logic [AW-1:0] pteh_i,
  input logic          done_o,
  input logic [AW-1:0] paddr_o,
  input logic [FAULT_W-1:0] fault_o,
  input logic          tlb_fault_o,
  input logic [AW-1:0] tea_o,
  input logic [AW-1:0] pteh_o
);
  // R11
  fault_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fault_o));

  // R11
  fault_zero_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != '0) |-> (paddr_o == '0));

  // R1
  priv_top_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && priv_i && vaddr_i[AW-1 -: 3] == 3'b111)
      |=> (done_o && paddr_o == $past(vaddr_i) && fault_o == '0));

  // R3
  user_aerr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !priv_i && vaddr_i[AW-1] &&
     !(vaddr_i[AW-1 -: 6] == 6'b111000 && !sq_lock_i))
      |=> (fault_o[F_AERR_RD] || fault_o[F_AERR_WR]) && !tlb_fault_o);

  // R10
  tlb_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (!tlb_fault_o ||
      (tea_o == $past(vaddr_i) &&
       pteh_o == {$past(vaddr_i[AW-1:VPN_LSB]), $past(pteh_i[VPN_LSB-1:0])})));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && fault_o == '0 && !tlb_fault_o));

  // R4
  xlat_off_strip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !xlat_en_i && !vaddr_i[AW-1])
      |=> (paddr_o == ($past(vaddr_i) & {3'b000, {(AW-3){1'b1}}}) && fault_o == '0));
endmodule

bind acc_region_guard acc_region_guard_chk #(.AW(AW), .FW(FW)) u_chk (.*);

// File: tb/acc_region_guard_tb.sv
module acc_region_guard_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic        write_i = 1'b0;
  logic        priv_i = 1'b0;
  logic        xlat_en_i = 1'b0;
  logic        sq_lock_i = 1'b0;
  logic        tlb_hit_i = 1'b0;
  logic        tlb_multi_i = 1'b0;
  logic [8:0]  tlb_flags_i = '0;
  logic [31:0] tlb_ppn_i = '0;
  logic [31:0] pteh_i = '0;
  logic        done_o;
  logic [31:0] paddr_o;
  logic [7:0]  fault_o;
  logic        tlb_fault_o;
  logic [31:0] tea_o;
  logic [31:0] pteh_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  acc_region_guard u_dut (.*);

  // expected fault vector from R3..R8 with R11 priority
  function automatic logic [7:0] exp_fault(input logic [31:0] a, input logic w, input logic p,
      input logic x, input logic lk, input logic h, input logic m, input logic [8:0] f);
    logic [7:0] r = '0;
    if (a[31] && !p) begin
      if (!(a >= 32'hE000_0000 && a < 32'hE400_0000 && !lk)) r[w ? 1 : 0] = 1'b1;
    end else if (a[31] && a < 32'hC000_0000) begin
    end else if (a >= 32'hE000_0000) begin
    end else if (x) begin
      if (m) r[2] = 1'b1;
      else if (!h) r[w ? 4 : 3] = 1'b1;
      else if (!w && !p && !f[6]) r[5] = 1'b1;
      else if (w && (p ? !f[5] : !(f[5] && f[6]))) r[6] = 1'b1;
      else if (w && !f[2]) r[7] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_pa(input logic [31:0] a, input logic p, input logic x,
      input logic [8:0] f, input logic [31:0] ppn);
    logic [31:0] mk;
    if (p && a >= 32'hE000_0000) return a;                   // R1
    if (!p && a[31]) return a;                               // R3 window
    if (a[31] && a < 32'hC000_0000) return a & 32'h1FFF_FFFF; // R2
    if (!x) return a & 32'h1FFF_FFFF;                        // R4
    case ({f[7], f[4]})                                      // R9
      2'b00: mk = 32'hFFFF_FC00;
      2'b01: mk = 32'hFFFF_F000;
      2'b10: mk = 32'hFFFF_0000;
      default: mk = 32'hFFF0_0000;
    endcase
    return (ppn & mk) | (a & ~mk);
  endfunction

  function automatic string tag_of(input logic [7:0] ef, input logic p, input logic [31:0] a,
      input logic x);
    if (ef[0] || ef[1]) return "R3";
    if (ef[2] || ef[3] || ef[4]) return "R5";
    if (ef[5]) return "R6";
    if (ef[6]) return "R7";
    if (ef[7]) return "R8";
    if (a[31] && a >= 32'hE000_0000) return p ? "R1" : "R3";
    if (a[31] && a < 32'hC000_0000) return "R2";
    if (!x) return "R4";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [71:0] got, input logic [71:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic p, input logic x,
      input logic lk, input logic h, input logic m, input logic [8:0] f, input logic [31:0] ppn,
      input logic [31:0] pt);
    logic [7:0]  ef;
    logic [31:0] ep;
    logic        etf;
    string       tg;
    @(negedge clk_i);
    valid_i = 1'b1; vaddr_i = a; write_i = w; priv_i = p; xlat_en_i = x; sq_lock_i = lk;
    tlb_hit_i = h; tlb_multi_i = m; tlb_flags_i = f; tlb_ppn_i = ppn; pteh_i = pt;
    ef  = exp_fault(a, w, p, x, lk, h, m, f);
    ep  = (ef != 0) ? 32'h0 : exp_pa(a, p, x, f, ppn);
    etf = |ef[7:2];
    tg  = tag_of(ef, p, a, x);
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tg, "/R11/R12"}, {31'd0, done_o, paddr_o, fault_o}, {31'd0, 1'b1, ep, ef});
    // R10
    check("R10", {7'd0, tlb_fault_o, tea_o, pteh_o},
          {7'd0, etf, etf ? a : 32'h0, etf ? {a[31:10], pt[9:0]} : 32'h0});
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12", {38'd0, done_o, fault_o, tlb_fault_o, paddr_o}, 72'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 / R2 / R4 boundaries
    access(32'hE000_0000, 0, 1, 1, 1, 0, 0, 9'h000, 0, 0);
    access(32'hFFFF_FFFF, 1, 1, 1, 1, 0, 0, 9'h000, 0, 0);
    access(32'hBFFF_FFFF, 0, 1, 1, 0, 0, 0, 9'h000, 0, 0);
    access(32'h8000_0000, 1, 1, 1, 0, 0, 0, 9'h000, 0, 0);
    access(32'hC000_0000, 0, 1, 0, 0, 0, 0, 9'h000, 0, 0);
    access(32'hDFFF_FFFF, 1, 1, 0, 0, 0, 0, 9'h000, 0, 0);
    access(32'h7FFF_FFFF, 0, 0, 0, 0, 1, 1, 9'h000, 0, 0);
    // R3 store-queue window edges
    access(32'hE000_0000, 0, 0, 1, 0, 0, 0, 9'h000, 0, 0);
    access(32'hE3FF_FFFF, 1, 0, 1, 0, 0, 0, 9'h000, 0, 0);
    access(32'hE400_0000, 0, 0, 1, 0, 0, 0, 9'h000, 0, 0);
    access(32'hE000_0040, 1, 0, 1, 1, 0, 0, 9'h000, 0, 0);
    access(32'h8000_0000, 1, 0, 0, 0, 1, 0, 9'h1FF, 0, 0);
    // R5 multi beats hit; misses by direction
    access(32'h1234_5678, 0, 1, 1, 0, 1, 1, 9'h1FF, 32'h0C00_0000, 32'hAAAA_AAAA);
    access(32'h1234_5678, 0, 1, 1, 0, 0, 0, 9'h000, 0, 32'h0000_03FF);
    access(32'h1234_5678, 1, 0, 1, 0, 0, 0, 9'h000, 0, 32'h0000_0155);
    // R6 / R7 / R8
    access(32'h0000_1000, 0, 0, 1, 0, 1, 0, 9'h024, 0, 0);
    access(32'h0000_1000, 0, 1, 1, 0, 1, 0, 9'h004, 32'h0C00_0000, 0);
    access(32'h0000_2000, 1, 1, 1, 0, 1, 0, 9'h040, 0, 0);
    access(32'h0000_2000, 1, 0, 1, 0, 1, 0, 9'h024, 0, 0);
    access(32'h0000_2000, 1, 1, 1, 0, 1, 0, 9'h020, 0, 0);
    access(32'h0000_2000, 1, 0, 1, 0, 1, 0, 9'h064, 32'h0C00_0000, 0);
    // R9 each page size
    access(32'h0123_4567, 0, 1, 1, 0, 1, 0, 9'h000, 32'hFEDC_BA98, 0);
    access(32'h0123_4567, 0, 1, 1, 0, 1, 0, 9'h010, 32'hFEDC_BA98, 0);
    access(32'h0123_4567, 0, 1, 1, 0, 1, 0, 9'h080, 32'hFEDC_BA98, 0);
    access(32'h0123_4567, 0, 1, 1, 0, 1, 0, 9'h090, 32'hFEDC_BA98, 0);
    // R12 idle cycle between requests
    @(negedge clk_i);
    check("R12", {38'd0, done_o, fault_o, tlb_fault_o, paddr_o}, 72'd0);
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      logic [2:0]  sel;
      sel = 3'($urandom_range(0, 7));
      a = $urandom;
      case (sel)
        3'd0: a[31:26] = 6'b111000;
        3'd1: a[31] = 1'b0;
        3'd2: a[31:29] = 3'b110;
        default: ;
      endcase
      access(a, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0), 1'($urandom),
             1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) == 0), 9'($urandom),
             $urandom, $urandom);
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule